// File: doc/BRIEF.md
# Multi-Channel Byte DMA Engine

This block is a direct memory access engine with several channels that copy bytes between memory-mapped addresses over one shared byte-wide bus. Before every bus access it raises a request and waits for a grant from the side that owns the bus. Each channel has its own start addresses, byte count per block, block count per transaction, address stepping for source and destination, trigger choice, and a pair of sticky status flags. Software programs the channels through a small register port.

A trigger starts one block on a channel. A transaction is finished after the programmed number of blocks. The channel then raises its interrupt, turns itself off and can put its start addresses back in place. Channels come in pairs (0 with 1, 2 with 3). When a linked channel completes, its partner is enabled and started, so the two can take turns without a gap. A fixed priority arbiter picks the lowest-numbered channel that has work again before every byte. A write that would land in the protected address window is never put on the bus.

Register port: `cfg_addr_i` is {channel, register}, with the register in the low three bits. 0 = control, 1 = source, 2 = destination, 3 = block length, 4 = block count, 5 = status. Control bits: [0] enable, [1] software start (reads as 0), [3:2] source step, [5:4] destination step (0 fixed, 1 increment, 2 decrement, 3 fixed), [6] restore addresses, [8:7] trigger choice (0 software only, 1 peripheral line, 2 event line), [9] link to partner. Status bits: [0] complete, [1] blocked-write error, [2] block in progress. Reading source or destination returns the working address.

Top module: `dma_engine`

## Requirements
- R1: While reset is asserted, and right after it, `bus_req_o` is low, every `irq_o` bit is low, and every status register reads 0.
- R2: Each started block copies exactly L bytes, in order, from the working source address to the working destination address. L is the length register, and a length of 0 means 2^LEN_W bytes.
- R3: After each byte, the source and destination addresses each step on their own by +1, -1 or 0, as set by their control field.
- R4: A transaction is made of N blocks, each needing its own trigger. N is the block count register, and 0 means 2^REP_W. Addresses carry on from one block to the next. Completion is flagged only after the last block.
- R5: At completion, if the restore bit is set, the working source and destination go back to the values last written to them. Otherwise they stay one step past the last byte moved.
- R6: A channel reacts only to the trigger line its control field selects, and only while it is enabled and idle. Pulses on the other line have no effect.
- R7: At completion the complete flag and the channel's `irq_o` bit go high and stay high until 1 is written to status bit 0. At the same time the enable bit clears.
- R8: When a channel with the link bit set completes, its partner channel (index XOR 1) becomes enabled and starts a block with no trigger.
- R9: Between bytes, the lowest-numbered channel with a block in progress gets the next byte. A higher-numbered block is cut short at a byte boundary.
- R10: A write whose destination lies in [PROT_LO, PROT_HI] is never driven on the bus. It still counts as a moved byte and sets the error flag, which is cleared by writing 1 to status bit 1.
- R11: While `bus_req_o` is high and `bus_gnt_i` is low, the address, direction and write data stay unchanged, and no transfer makes progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | CH_W+3 | {channel, register} |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data (combinational) |
| trig_periph_i | input | NCH | Peripheral trigger line per channel |
| trig_event_i | input | NCH | Event trigger line per channel |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; an access completes in a cycle with request and grant both high |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid in the granted read cycle |
| irq_o | output | NCH | Per-channel completion interrupt |

## Verification
The bench builds the engine with four channels, 12-bit addresses, a 4-bit length field and a 3-bit block count, and places the protected window at 0xF00–0xFFF. The narrow length field makes the zero-means-maximum case a 16-byte block. The narrow block count makes the zero-means-maximum case a transaction of eight triggers. With these sizes, both wrap cases and the blocked window fit inside a 4 KB memory model. The grant line is under direct control, so stalls and the byte-boundary preemption between two channels can be observed cycle by cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    STEP_FIX = 2'd0,
    STEP_INC = 2'd1,
    STEP_DEC = 2'd2,
    STEP_RSV = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    TRG_SW     = 2'd0,
    TRG_PERIPH = 2'd1,
    TRG_EVENT  = 2'd2,
    TRG_RSV    = 2'd3
  } trg_e;

  typedef struct packed {
    logic  link;
    trg_e  tsel;
    logic  restore;
    step_e dstep;
    step_e sstep;
    logic  swgo;
    logic  en;
  } ctrl_t;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_LEN  = 3'd3;
  localparam logic [2:0] REG_REP  = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  function automatic logic [31:0] addr_step(input logic [31:0] a, input step_e m);
    case (m)
      STEP_INC: return a + 32'd1;
      STEP_DEC: return a - 32'd1;
      default:  return a;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    reg_i,
  input  logic [15:0]   wdata_i,
  input  logic          trig_p_i,
  input  logic          trig_e_i,
  input  logic          link_start_i,
  input  logic          byte_done_i,
  input  logic          wr_blocked_i,
  output logic          want_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [15:0]   rdata_o,
  output logic          irq_o,
  output logic          link_fire_o
);

  ctrl_t            ctrl_q;
  logic [AW-1:0]    src0_q, dst0_q, src_q, dst_q;
  logic [LEN_W-1:0] len_q;
  logic [REP_W-1:0] rep_q;
  logic [LEN_W:0]   bcnt_q, len_ld;
  logic [REP_W:0]   rcnt_q, rep_ld;
  logic             busy_q, done_q, err_q;
  logic             sel_trig, last_byte, last_blk;
  ctrl_t            wctrl;

  // zero in a count field selects the full power-of-two range
  assign len_ld = {len_q == '0, len_q};
  assign rep_ld = {rep_q == '0, rep_q};

  assign sel_trig = (ctrl_q.tsel == TRG_PERIPH && trig_p_i) ||
                    (ctrl_q.tsel == TRG_EVENT  && trig_e_i);
  assign last_byte   = byte_done_i && bcnt_q == (LEN_W+1)'(1);
  assign last_blk    = last_byte && rcnt_q == (REP_W+1)'(1);
  assign link_fire_o = last_blk && ctrl_q.link;

  always_comb begin
    wctrl      = ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
    wctrl.swgo = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src0_q <= '0;
      dst0_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      rep_q  <= '0;
      bcnt_q <= '0;
      rcnt_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (byte_done_i) begin
        src_q  <= AW'(addr_step(32'(src_q), ctrl_q.sstep));
        dst_q  <= AW'(addr_step(32'(dst_q), ctrl_q.dstep));
        bcnt_q <= bcnt_q - 1'b1;
        if (last_byte) begin
          busy_q <= 1'b0;
          rcnt_q <= rcnt_q - 1'b1;
          if (last_blk) begin
            done_q    <= 1'b1;
            ctrl_q.en <= 1'b0;
            rcnt_q    <= rep_ld;
            if (ctrl_q.restore) begin
              src_q <= src0_q;
              dst_q <= dst0_q;
            end
          end
        end
      end else if (link_start_i) begin
        ctrl_q.en <= 1'b1;
        busy_q    <= 1'b1;
        bcnt_q    <= len_ld;
        rcnt_q    <= rep_ld;
      end else if (ctrl_q.en && !busy_q && sel_trig) begin
        busy_q <= 1'b1;
        bcnt_q <= len_ld;
      end

      if (wr_blocked_i) err_q <= 1'b1;

      if (wr_i) begin
        case (reg_i)
          REG_CTRL: begin
            ctrl_q <= wctrl;
            if (wdata_i[0] && !ctrl_q.en) rcnt_q <= rep_ld;
            if (wdata_i[0] && wdata_i[1] && !busy_q) begin
              busy_q <= 1'b1;
              bcnt_q <= len_ld;
            end
          end
          REG_SRC: begin
            src0_q <= wdata_i[AW-1:0];
            src_q  <= wdata_i[AW-1:0];
          end
          REG_DST: begin
            dst0_q <= wdata_i[AW-1:0];
            dst_q  <= wdata_i[AW-1:0];
          end
          REG_LEN: len_q <= wdata_i[LEN_W-1:0];
          REG_REP: rep_q <= wdata_i[REP_W-1:0];
          REG_STAT: begin
            if (wdata_i[0]) done_q <= 1'b0;
            if (wdata_i[1]) err_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_i)
      REG_CTRL: rdata_o = 16'(ctrl_q);
      REG_SRC:  rdata_o = 16'(src_q);
      REG_DST:  rdata_o = 16'(dst_q);
      REG_LEN:  rdata_o = 16'(len_q);
      REG_REP:  rdata_o = 16'(rep_q);
      REG_STAT: rdata_o = {13'd0, busy_q, err_q, done_q};
      default:  rdata_o = '0;
    endcase
  end

  assign want_o = ctrl_q.en && busy_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign irq_o  = done_q;

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic [NCH-1:0]  req_i,
  output logic            any_o,
  output logic [CH_W-1:0] win_o
);

  always_comb begin
    win_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) win_o = CH_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   CH_W    = 2,
  parameter logic [AW-1:0] PROT_LO = '1,
  parameter logic [AW-1:0] PROT_HI = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            any_i,
  input  logic [CH_W-1:0] win_i,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  output logic [CH_W-1:0] cur_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [7:0]      bus_wdata_o,
  input  logic            bus_gnt_i,
  input  logic [7:0]      bus_rdata_i,
  output logic            byte_done_o,
  output logic            blocked_o
);

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR} mv_e;

  mv_e             st_q;
  logic [CH_W-1:0] cur_q;
  logic [7:0]      data_q;
  logic            dst_prot;

  assign dst_prot = (dst_i >= PROT_LO) && (dst_i <= PROT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MV_IDLE;
      cur_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        MV_IDLE: if (any_i) begin
          cur_q <= win_i;
          st_q  <= MV_RD;
        end
        MV_RD: if (bus_gnt_i) begin
          data_q <= bus_rdata_i;
          st_q   <= dst_prot ? MV_IDLE : MV_WR;
        end
        MV_WR: if (bus_gnt_i) st_q <= MV_IDLE;
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q == MV_RD) || (st_q == MV_WR);
  assign bus_we_o    = (st_q == MV_WR);
  assign bus_addr_o  = (st_q == MV_WR) ? dst_i : src_i;
  assign bus_wdata_o = data_q;
  assign blocked_o   = (st_q == MV_RD) && bus_gnt_i && dst_prot;
  assign byte_done_o = blocked_o || ((st_q == MV_WR) && bus_gnt_i);
  assign cur_o       = cur_q;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned   NCH     = 4,
  parameter int unsigned   AW      = 16,
  parameter int unsigned   LEN_W   = 16,
  parameter int unsigned   REP_W   = 8,
  parameter logic [AW-1:0] PROT_LO = AW'(16'hF000),
  parameter logic [AW-1:0] PROT_HI = '1,
  localparam int unsigned  CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned  CFG_AW  = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  input  logic [NCH-1:0]    trig_periph_i,
  input  logic [NCH-1:0]    trig_event_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  output logic [NCH-1:0]    irq_o
);

  logic [NCH-1:0]  want, link_fire;
  logic [AW-1:0]   src_a [NCH];
  logic [AW-1:0]   dst_a [NCH];
  logic [15:0]     rd_a  [NCH];
  logic [CH_W-1:0] cur, win, cfg_ch;
  logic            any, byte_done, blocked;

  assign cfg_ch = cfg_addr_i[CFG_AW-1:3];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(
      .AW   (AW),
      .LEN_W(LEN_W),
      .REP_W(REP_W)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (cfg_we_i && cfg_ch == CH_W'(g)),
      .reg_i       (cfg_addr_i[2:0]),
      .wdata_i     (cfg_wdata_i),
      .trig_p_i    (trig_periph_i[g]),
      .trig_e_i    (trig_event_i[g]),
      .link_start_i(link_fire[g ^ 1]),
      .byte_done_i (byte_done && cur == CH_W'(g)),
      .wr_blocked_i(blocked && cur == CH_W'(g)),
      .want_o      (want[g]),
      .src_o       (src_a[g]),
      .dst_o       (dst_a[g]),
      .rdata_o     (rd_a[g]),
      .irq_o       (irq_o[g]),
      .link_fire_o (link_fire[g])
    );
  end

  dma_arb #(
    .NCH (NCH),
    .CH_W(CH_W)
  ) u_arb (
    .req_i(want),
    .any_o(any),
    .win_o(win)
  );

  dma_mover #(
    .AW     (AW),
    .CH_W   (CH_W),
    .PROT_LO(PROT_LO),
    .PROT_HI(PROT_HI)
  ) u_mover (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any),
    .win_i      (win),
    .src_i      (src_a[cur]),
    .dst_i      (dst_a[cur]),
    .cur_o      (cur),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_gnt_i  (bus_gnt_i),
    .bus_rdata_i(bus_rdata_i),
    .byte_done_o(byte_done),
    .blocked_o  (blocked)
  );

  assign cfg_rdata_o = rd_a[cfg_ch];

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int unsigned   NCH     = 4,
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] PROT_LO = '1,
  parameter logic [AW-1:0] PROT_HI = '1,
  localparam int unsigned  CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CH_W+2:0]   cfg_addr_i,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_we_o,
  input logic [AW-1:0]     bus_addr_o,
  input logic [7:0]        bus_wdata_o,
  input logic [NCH-1:0]    irq_o
);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      quiet_in_reset_chk: assert (!bus_req_o && irq_o == '0);
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  // R10
  no_prot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> !(bus_addr_o >= PROT_LO && bus_addr_o <= PROT_HI));

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    // R7
    irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] && !(cfg_we_i && cfg_addr_i == {CH_W'(i), 3'd5}) |=> irq_o[i]);
  end

endmodule

bind dma_engine dma_engine_chk #(
  .NCH    (NCH),
  .AW     (AW),
  .PROT_LO(PROT_LO),
  .PROT_HI(PROT_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .irq_o      (irq_o)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;

  localparam int NCH = 4;
  localparam int AW  = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [4:0]     cfg_addr = '0;
  logic [15:0]    cfg_wdata = '0;
  logic [15:0]    cfg_rdata;
  logic [NCH-1:0] trig_p = '0, trig_e = '0;
  logic           bus_req, bus_we, gnt_en = 1'b1;
  logic [AW-1:0]  bus_addr;
  logic [7:0]     bus_wdata, bus_rdata;
  logic [NCH-1:0] irq;

  logic [7:0]     mem [4096];
  logic [AW-1:0]  wlog [1024];
  int             wcnt = 0;
  int             prot_hits = 0;
  int             n_chk = 0, n_fail = 0;
  int             cyc = 0;

  always #10 clk = ~clk;

  dma_engine #(
    .NCH(NCH), .AW(AW), .LEN_W(4), .REP_W(3),
    .PROT_LO(12'hF00), .PROT_HI(12'hFFF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .trig_periph_i(trig_p), .trig_event_i(trig_e),
    .bus_req_o(bus_req), .bus_gnt_i(gnt_en), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .irq_o(irq)
  );

  assign bus_rdata = mem[bus_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && gnt_en && bus_we) begin
      mem[bus_addr] <= bus_wdata;
      if (wcnt < 1024) wlog[wcnt] <= bus_addr;
      wcnt <= wcnt + 1;
      if (bus_addr >= 12'hF00) prot_hits <= prot_hits + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [15:0] ctrl(input bit en, input bit go, input int ss, input int ds,
                                       input bit rst, input int ts, input bit lk);
    return {6'd0, lk, 2'(ts), rst, 2'(ds), 2'(ss), go, en};
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int r, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'(ch), 3'(r)}; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, output logic [15:0] d);
    cfg_addr = {2'(ch), 3'(r)};
    #1 d = cfg_rdata;
  endtask

  task automatic setup(input int ch, input int s, input int d, input int len, input int rep);
    wr(ch, 5, 3);
    wr(ch, 1, s); wr(ch, 2, d); wr(ch, 3, len); wr(ch, 4, rep);
  endtask

  task automatic wait_irq(input int ch, input string rq);
    int k;
    for (k = 0; k < 500 && !irq[ch]; k++) @(negedge clk);
    chk(irq[ch], rq, 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit ev, input int ch);
    @(negedge clk);
    if (ev) trig_e[ch] = 1'b1; else trig_p[ch] = 1'b1;
    @(negedge clk);
    trig_e = '0; trig_p = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(!bus_req, "R1 bus_req", bus_req, 0);
    chk(irq == '0, "R1 irq", irq, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, 5, d);
      chk(d == 0, "R1 status", d, 0);
    end
  endtask

  task automatic t_basic();
    logic [15:0] d;
    setup(0, 'h100, 'h200, 5, 1);
    wr(0, 0, ctrl(1, 1, 1, 1, 0, 0, 0));
    wait_irq(0, "R2 basic done");
    for (int k = 0; k < 5; k++)
      chk(mem['h200 + k] == pat('h100 + k), "R2 basic byte", mem['h200 + k], pat('h100 + k));
    chk(mem['h205] == pat('h205), "R2 no overrun", mem['h205], pat('h205));
    rd(0, 5, d);
    chk(d == 16'h1, "R7 status complete", d, 1);
    rd(0, 0, d);
    chk(d[0] == 1'b0, "R7 enable cleared", d[0], 0);
    idle(3);
    chk(irq[0], "R7 irq sticky", irq[0], 1);
    wr(0, 5, 1);
    chk(!irq[0], "R7 irq cleared", irq[0], 0);
  endtask

  task automatic t_len0();
    setup(1, 'h110, 'h220, 0, 1);
    wr(1, 0, ctrl(1, 1, 1, 1, 0, 0, 0));
    wait_irq(1, "R2 len0 done");
    chk(mem['h22F] == pat('h11F), "R2 len0 last byte", mem['h22F], pat('h11F));
    chk(mem['h230] == pat('h230), "R2 len0 stop", mem['h230], pat('h230));
  endtask

  task automatic t_modes();
    logic [15:0] d;
    setup(0, 'h143, 'h240, 4, 1);
    wr(0, 0, ctrl(1, 1, 2, 1, 0, 0, 0));
    wait_irq(0, "R3 dec/inc done");
    for (int k = 0; k < 4; k++)
      chk(mem['h240 + k] == pat('h143 - k), "R3 src dec", mem['h240 + k], pat('h143 - k));
    rd(0, 1, d);
    chk(d == 16'h13F, "R5 no restore src", d, 'h13F);
    setup(0, 'h150, 'h24F, 3, 1);
    wr(0, 0, ctrl(1, 1, 0, 2, 0, 0, 0));
    wait_irq(0, "R3 fix/dec done");
    for (int k = 0; k < 3; k++)
      chk(mem['h24F - k] == pat('h150), "R3 dst dec src fixed", mem['h24F - k], pat('h150));
    chk(mem['h24C] == pat('h24C), "R3 dst dec stop", mem['h24C], pat('h24C));
    wr(0, 5, 1);
  endtask

  task automatic t_repeat();
    logic [15:0] d;
    setup(2, 'h160, 'h260, 2, 3);
    wr(2, 0, ctrl(1, 0, 1, 1, 0, 1, 0));
    pulse(0, 2); idle(20);
    rd(2, 5, d);
    chk(d == 0, "R4 not complete after block 1", d, 0);
    rd(2, 1, d);
    chk(d == 16'h162, "R4 address carries", d, 'h162);
    pulse(0, 2); idle(20);
    chk(!irq[2], "R4 not complete after block 2", irq[2], 0);
    pulse(0, 2);
    wait_irq(2, "R4 complete after block 3");
    chk(mem['h265] == pat('h165), "R4 last byte", mem['h265], pat('h165));
    rd(2, 1, d);
    chk(d == 16'h166, "R5 no restore", d, 'h166);
    wr(2, 5, 1);
    // block count 0 means 8 blocks
    setup(3, 'h168, 'h268, 1, 0);
    wr(3, 0, ctrl(1, 0, 1, 1, 0, 2, 0));
    for (int k = 0; k < 7; k++) begin pulse(1, 3); idle(8); end
    chk(!irq[3], "R4 rep0 not complete after 7", irq[3], 0);
    pulse(1, 3);
    wait_irq(3, "R4 rep0 complete after 8");
    chk(mem['h26F] == pat('h16F), "R4 rep0 byte 8", mem['h26F], pat('h16F));
    wr(3, 5, 1);
  endtask

  task automatic t_restore();
    logic [15:0] d;
    setup(1, 'h170, 'h270, 3, 1);
    wr(1, 0, ctrl(1, 1, 1, 1, 1, 0, 0));
    wait_irq(1, "R5 restore done");
    rd(1, 1, d);
    chk(d == 16'h170, "R5 src restored", d, 'h170);
    rd(1, 2, d);
    chk(d == 16'h270, "R5 dst restored", d, 'h270);
    chk(mem['h272] == pat('h172), "R5 copy", mem['h272], pat('h172));
  endtask

  task automatic t_trigsel();
    logic [15:0] d;
    setup(1, 'h180, 'h280, 2, 1);
    wr(1, 0, ctrl(1, 0, 1, 1, 0, 2, 0));
    pulse(0, 1); idle(20);
    rd(1, 5, d);
    chk(d == 0, "R6 wrong line ignored status", d, 0);
    chk(mem['h280] == pat('h280), "R6 wrong line no copy", mem['h280], pat('h280));
    pulse(1, 1);
    wait_irq(1, "R6 selected line");
    chk(mem['h281] == pat('h181), "R6 copy", mem['h281], pat('h181));
    wr(1, 5, 1);
  endtask

  task automatic t_link();
    logic [15:0] d;
    setup(3, 'h190, 'h290, 2, 1);
    wr(3, 0, ctrl(0, 0, 1, 1, 0, 0, 0));
    setup(2, 'h1A0, 'h2A0, 2, 1);
    wr(2, 0, ctrl(1, 1, 1, 1, 0, 0, 1));
    wait_irq(2, "R8 first done");
    wait_irq(3, "R8 partner done");
    chk(mem['h291] == pat('h191), "R8 partner copy", mem['h291], pat('h191));
    rd(3, 0, d);
    chk(d[0] == 1'b0, "R8 partner enable cleared", d[0], 0);
    wr(2, 5, 1); wr(3, 5, 1);
  endtask

  task automatic t_prio();
    int b;
    setup(0, 'h1C0, 'h2C0, 3, 1);
    wr(0, 0, ctrl(1, 0, 1, 1, 0, 1, 0));
    setup(1, 'h1D0, 'h2D0, 3, 1);
    wr(1, 0, ctrl(1, 0, 1, 1, 0, 1, 0));
    b = wcnt;
    @(negedge clk); trig_p[1] = 1'b1;
    @(negedge clk); trig_p = 4'b0001;
    @(negedge clk); trig_p = '0;
    wait_irq(1, "R9 both done");
    chk(wlog[b] == 12'h2D0, "R9 first byte ch1", wlog[b], 'h2D0);
    chk(wlog[b+1] == 12'h2C0, "R9 ch0 preempts", wlog[b+1], 'h2C0);
    chk(wlog[b+3] == 12'h2C2, "R9 ch0 runs through", wlog[b+3], 'h2C2);
    chk(wlog[b+4] == 12'h2D1, "R9 ch1 resumes", wlog[b+4], 'h2D1);
    chk(irq[0], "R9 ch0 done", irq[0], 1);
    wr(0, 5, 1); wr(1, 5, 1);
  endtask

  task automatic t_protect();
    logic [15:0] d;
    setup(0, 'h1E0, 'hF00, 2, 1);
    wr(0, 0, ctrl(1, 1, 1, 1, 0, 0, 0));
    wait_irq(0, "R10 done");
    rd(0, 5, d);
    chk(d == 16'h3, "R10 error flag", d, 3);
    chk(prot_hits == 0, "R10 no bus write", prot_hits, 0);
    chk(mem['hF00] == pat('hF00), "R10 memory intact", mem['hF00], pat('hF00));
    wr(0, 5, 2);
    rd(0, 5, d);
    chk(d == 16'h1, "R10 error cleared", d, 1);
    wr(0, 5, 1);
  endtask

  task automatic t_stall();
    logic [AW-1:0] a0;
    setup(1, 'h1F0, 'h2F0, 1, 1);
    gnt_en = 1'b0;
    wr(1, 0, ctrl(1, 1, 1, 1, 0, 0, 0));
    idle(3);
    a0 = bus_addr;
    chk(bus_req && !bus_we && a0 == 12'h1F0, "R11 read held", a0, 'h1F0);
    idle(5);
    chk(bus_req && bus_addr == a0, "R11 stable under stall", bus_addr, a0);
    chk(mem['h2F0] == pat('h2F0), "R11 no progress", mem['h2F0], pat('h2F0));
    gnt_en = 1'b1;
    wait_irq(1, "R11 resumes");
    chk(mem['h2F0] == pat('h1F0), "R11 copy", mem['h2F0], pat('h1F0));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_len0();
    t_modes();
    t_repeat();
    t_restore();
    t_trigsel();
    t_link();
    t_prio();
    t_protect();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule